// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block is the datapath behind rotate-then-mask integer operations. A 64-bit source word is rotated left by a shift amount. In parallel, a contiguous run of ones is built between two bounds. The unit returns the rotated word, the mask, and the two ANDed together. Bit positions are counted from the most significant end: position 0 is vector bit 63. When the begin bound lies after the end bound, the run of ones wraps past position 63 back to position 0.

A word-mode select serves 32-bit operations. In word mode the low half of the source is copied into both halves before the 64-bit rotate. Each bound keeps only its low five bits and is moved into the lower half of the word by adding 32. The three results go through an output register that loads when the input strobe is high. A flag marks the cycle in which fresh results are present. Setting the `REG_OUT` parameter to 0 removes that register.

Top module: `rotmask_unit`

## Requirements
- R1: With `wordMode`=0, `outRotated` is `srcValue` rotated left by `shiftAmt` modulo 64. Only bits [5:0] of `shiftAmt` matter, so 74 rotates the same as 10. Example: 0xdeadbeef12345678 rotated by 10 gives 0xb6fbbc48d159e37a, and by 35 gives 0x91a2b3c6f56df778.
- R2: With `wordMode`=1, `srcValue[31:0]` is copied into both halves of a 64-bit word, and that word is rotated left as in R1. `srcValue[63:32]` has no effect. Example: low word 0xdeadbeef rotated by 10 gives 0xb6fbbf7ab6fbbf7a.
- R3: Position p of the mask is vector bit 63-p. When begin ≤ end, the mask has ones at positions begin through end inclusive and zeros elsewhere. Examples: (32,32) gives 0x0000000080000000, (37,63) gives 0x7ffffff, (0,37) gives 0xfffffffffc000000, and (0,58) gives 0xffffffffffffffe0.
- R4: When begin > end, the mask has ones at positions begin..63 and 0..end, with zeros between them. Example: (47,37) gives 0xfffffffffc01ffff.
- R5: With `wordMode`=1, each effective bound is 32 plus bits [4:0] of the bound input, and bit 5 of the bound is ignored. Example: bounds (5,15) or (37,47) both give 0x7ff0000.
- R6: `outResult` equals `outRotated` AND `outMask`.
- R7: With `REG_OUT`=1, all three results for the inputs present at a rising edge where `inValid` is high appear after that edge. `outValid` is high during exactly the cycle that follows such an edge.
- R8: At an edge where `inValid` is low, all three data outputs keep their values whatever the other inputs do, and `outValid` is low in the following cycle.
- R9: While `rst_n` is low, all data outputs are zero and `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Loads the output stage with the current operands |
| wordMode | input | 1 | 1 selects the 32-bit rotate and bound offset |
| srcValue | input | 64 | Source operand |
| shiftAmt | input | 7 | Rotate amount; the upper bit is dropped |
| maskBegin | input | 6 | First mask position, counted from the MSB |
| maskEnd | input | 6 | Last mask position, counted from the MSB |
| outRotated | output | 64 | Rotated source |
| outMask | output | 64 | Generated mask |
| outResult | output | 64 | Rotated source ANDed with the mask |
| outValid | output | 1 | High in the cycle after a load |

## Verification
The hardest case to reach from the ports is the edge of the wrap: begin exactly one past end, which gives an all-ones mask, next to begin equal to end, which gives a single bit. Random bounds almost never land on these pairs. The stimulus therefore sweeps begin through every position with end set to begin-1 and to begin, in both word modes. A long deterministic pseudo-random run follows, and the scoreboard compares every result against a bit-by-bit model.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  // Strobes handed from control to datapath
  typedef struct packed {
    logic capture;  // load the output stage this edge
    logic dupLow;   // copy the low half into both halves before rotating
  } rmStrobe_t;
endpackage

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int DATA_W = 64,
  localparam int POS_W = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]  beginPos,
  input  logic [POS_W-1:0]  endPos,
  output logic [DATA_W-1:0] maskOut
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] fromBegin;  // positions beginPos .. DATA_W-1
  logic [DATA_W-1:0] upToEnd;    // positions 0 .. endPos
  logic wrapMode;

  assign fromBegin = ALL_ONES >> beginPos;
  assign upToEnd   = ~((ALL_ONES >> endPos) >> 1);
  assign wrapMode  = beginPos > endPos;
  assign maskOut   = wrapMode ? (fromBegin | upToEnd) : (fromBegin & upToEnd);

  // Ones count must match the bound distance (R3 straight run, R4 wrapped run)
  int expCount;
  always_comb begin
    if (wrapMode) expCount = DATA_W - (int'(beginPos) - int'(endPos) - 1);
    else          expCount = int'(endPos) - int'(beginPos) + 1;
    p_mask_count_r3: assert ($countones(maskOut) == expCount);
  end
endmodule

// File: rtl/rotmask_ctrl.sv
module rotmask_ctrl
  import rotmask_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int AMT_W   = 7,
  parameter bit REG_OUT = 1'b1,
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             wordMode,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic [POS_W-1:0] maskBegin,
  input  logic [POS_W-1:0] maskEnd,
  output rmStrobe_t        strobe,
  output logic [POS_W-1:0] effAmt,
  output logic [POS_W-1:0] effBegin,
  output logic [POS_W-1:0] effEnd,
  output logic             outValid
);
  // Word mode places the bounds in the lower half (offset DATA_W/2)
  assign effBegin = wordMode ? {1'b1, maskBegin[POS_W-2:0]} : maskBegin;
  assign effEnd   = wordMode ? {1'b1, maskEnd[POS_W-2:0]}   : maskEnd;
  // Rotation is modulo the word length
  assign effAmt   = shiftAmt[POS_W-1:0];

  assign strobe.capture = inValid;
  assign strobe.dupLow  = wordMode;

  generate
    if (REG_OUT) begin : g_validReg
      logic validQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) validQ <= 1'b0;
        else        validQ <= inValid;
      end
      assign outValid = validQ;

      p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inValid |=> outValid);
      p_valid_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inValid |=> !outValid);
    end else begin : g_validComb
      assign outValid = inValid;
    end
  endgenerate
endmodule

// File: rtl/rotmask_dp.sv
module rotmask_dp
  import rotmask_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int POS_W  = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rmStrobe_t         strobe,
  input  logic [DATA_W-1:0] srcValue,
  input  logic [POS_W-1:0]  effAmt,
  input  logic [POS_W-1:0]  effBegin,
  input  logic [POS_W-1:0]  effEnd,
  output logic [DATA_W-1:0] outRotated,
  output logic [DATA_W-1:0] outMask,
  output logic [DATA_W-1:0] outResult
);
  logic [DATA_W-1:0] preparedVal;
  logic [DATA_W-1:0] rotStage [POS_W+1];
  logic [DATA_W-1:0] rotVal, maskVal, andVal;

  assign preparedVal = strobe.dupLow ? {srcValue[HALF_W-1:0], srcValue[HALF_W-1:0]}
                                     : srcValue;
  assign rotStage[0] = preparedVal;

  // Log-depth left rotator: stage s rotates by 2**s when amount bit s is set
  generate
    for (genvar s = 0; s < POS_W; s++) begin : g_rotStage
      localparam int SH = 1 << s;
      assign rotStage[s+1] = effAmt[s]
        ? {rotStage[s][DATA_W-1-SH:0], rotStage[s][DATA_W-1:DATA_W-SH]}
        : rotStage[s];
    end
  endgenerate
  assign rotVal = rotStage[POS_W];

  // A rotation only moves bits (R1, R2)
  always_comb begin
    p_rot_keeps_ones_r1: assert ($countones(rotVal) == $countones(preparedVal));
  end

  rotmask_maskgen #(.DATA_W(DATA_W)) i_maskgen (
    .beginPos (effBegin),
    .endPos   (effEnd),
    .maskOut  (maskVal)
  );

  assign andVal = rotVal & maskVal;

  generate
    if (REG_OUT) begin : g_outReg
      logic [DATA_W-1:0] rotQ, maskQ, resQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rotQ  <= '0;
          maskQ <= '0;
          resQ  <= '0;
        end else if (strobe.capture) begin
          rotQ  <= rotVal;
          maskQ <= maskVal;
          resQ  <= andVal;
        end
      end
      assign outRotated = rotQ;
      assign outMask    = maskQ;
      assign outResult  = resQ;

      p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe.capture |=> ($stable(outRotated) && $stable(outMask) && $stable(outResult)));
    end else begin : g_outComb
      assign outRotated = rotVal;
      assign outMask    = maskVal;
      assign outResult  = andVal;
    end
  endgenerate

  p_result_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (outResult & ~outMask) == '0);
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int AMT_W   = 7,
  parameter bit REG_OUT = 1'b1,
  localparam int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              wordMode,
  input  logic [DATA_W-1:0] srcValue,
  input  logic [AMT_W-1:0]  shiftAmt,
  input  logic [POS_W-1:0]  maskBegin,
  input  logic [POS_W-1:0]  maskEnd,
  output logic [DATA_W-1:0] outRotated,
  output logic [DATA_W-1:0] outMask,
  output logic [DATA_W-1:0] outResult,
  output logic              outValid
);
  rmStrobe_t        strobe;
  logic [POS_W-1:0] effAmt, effBegin, effEnd;

  rotmask_ctrl #(.DATA_W(DATA_W), .AMT_W(AMT_W), .REG_OUT(REG_OUT)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .wordMode  (wordMode),
    .shiftAmt  (shiftAmt),
    .maskBegin (maskBegin),
    .maskEnd   (maskEnd),
    .strobe    (strobe),
    .effAmt    (effAmt),
    .effBegin  (effBegin),
    .effEnd    (effEnd),
    .outValid  (outValid)
  );

  rotmask_dp #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .srcValue   (srcValue),
    .effAmt     (effAmt),
    .effBegin   (effBegin),
    .effEnd     (effEnd),
    .outRotated (outRotated),
    .outMask    (outMask),
    .outResult  (outResult)
  );
endmodule

// File: tb/test_rotmask_unit.sv
module test_rotmask_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] rot;
    logic [63:0] msk;
    logic [63:0] res;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        wordMode = 1'b0;
  logic [63:0] srcValue = '0;
  logic [6:0]  shiftAmt = '0;
  logic [5:0]  maskBegin = '0;
  logic [5:0]  maskEnd = '0;
  logic [63:0] outRotated, outMask, outResult;
  logic        outValid;

  int checks = 0;
  int fails  = 0;
  expItem_t scoreQ[$];
  expItem_t lastExp;

  always #(CLK_PERIOD/2) clk = ~clk;

  rotmask_unit i_rotmask_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .wordMode(wordMode),
    .srcValue(srcValue), .shiftAmt(shiftAmt), .maskBegin(maskBegin),
    .maskEnd(maskEnd), .outRotated(outRotated), .outMask(outMask),
    .outResult(outResult), .outValid(outValid)
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model, built bit by bit from the requirements
  function automatic expItem_t model(input logic [63:0] src, input logic [6:0] amt,
                                     input logic m32, input logic [5:0] b, input logic [5:0] e);
    expItem_t it;
    logic [63:0] prep;
    int a, eb, ee;
    prep = m32 ? {src[31:0], src[31:0]} : src;
    a = int'(amt) % 64;
    eb = m32 ? 32 + int'(b[4:0]) : int'(b);
    ee = m32 ? 32 + int'(e[4:0]) : int'(e);
    for (int i = 0; i < 64; i++) it.rot[(i + a) % 64] = prep[i];
    for (int p = 0; p < 64; p++)
      it.msk[63-p] = (eb <= ee) ? (p >= eb && p <= ee) : (p >= eb || p <= ee);
    it.res = it.rot & it.msk;
    it.tag = "";
    return it;
  endfunction

  task automatic applyVec(input logic [63:0] src, input logic [6:0] amt, input logic m32,
                          input logic [5:0] b, input logic [5:0] e, input string tag,
                          input bit useRot = 0, input logic [63:0] refRot = '0,
                          input bit useMsk = 0, input logic [63:0] refMsk = '0);
    expItem_t it;
    it = model(src, amt, m32, b, e);
    if (useRot) it.rot = refRot;
    if (useMsk) it.msk = refMsk;
    it.res = it.rot & it.msk;
    it.tag = tag;
    @(negedge clk);
    srcValue = src; shiftAmt = amt; wordMode = m32;
    maskBegin = b; maskEnd = e; inValid = 1'b1;
    scoreQ.push_back(it);
    lastExp = it;
  endtask

  // Monitor: pops one expected item per valid result
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      if (scoreQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 actual=unexpected valid expected=no result");
      end else begin
        expItem_t it;
        it = scoreQ.pop_front();
        check64({it.tag, " rotated"}, outRotated, it.rot);
        check64({it.tag, " mask"}, outMask, it.msk);
        check64({"R6 ", it.tag, " result"}, outResult, it.res);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] lfsr;
    repeat (2) @(negedge clk);
    // R9: reset state
    check64("R9 rotated", outRotated, '0);
    check64("R9 mask", outMask, '0);
    check64("R9 result", outResult, '0);
    check64("R9 valid", {63'd0, outValid}, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 stated rotations
    applyVec(64'hdeadbeef12345678, 7'd10, 0, 0, 63, "R1 rot10", 1, 64'hb6fbbc48d159e37a);
    applyVec(64'hdeadbeef12345678, 7'd35, 0, 0, 63, "R1 rot35", 1, 64'h91a2b3c6f56df778);
    applyVec(64'hdeadbeef12345678, 7'd58, 0, 0, 63, "R1 rot58", 1, 64'he37ab6fbbc48d159);
    applyVec(64'hdeadbeef12345678, 7'd74, 0, 0, 63, "R1 amt74", 1, 64'hb6fbbc48d159e37a);
    // R2 word rotate, upper half ignored
    applyVec(64'h12345678deadbeef, 7'd10, 1, 0, 31, "R2 word10", 1, 64'hb6fbbf7ab6fbbf7a);
    // R3 and R4 stated masks
    applyVec(64'hffffffffffffffff, 7'd0, 0, 32, 32, "R3 m32_32", 0, 0, 1, 64'h0000000080000000);
    applyVec(64'hffffffffffffffff, 7'd0, 0, 37, 63, "R3 m37_63", 0, 0, 1, 64'h0000000007ffffff);
    applyVec(64'hffffffffffffffff, 7'd0, 0, 0, 37, "R3 m0_37", 0, 0, 1, 64'hfffffffffc000000);
    applyVec(64'hffffffffffffffff, 7'd0, 0, 0, 58, "R3 m0_58", 0, 0, 1, 64'hffffffffffffffe0);
    applyVec(64'hffffffffffffffff, 7'd0, 0, 47, 37, "R4 m47_37", 0, 0, 1, 64'hfffffffffc01ffff);
    // R5 word bounds with bit 5 ignored
    applyVec(64'hffffffffffffffff, 7'd0, 1, 5, 15, "R5 w5_15", 0, 0, 1, 64'h0000000007ff0000);
    applyVec(64'hffffffffffffffff, 7'd0, 1, 37, 47, "R5 w37_47", 0, 0, 1, 64'h0000000007ff0000);
    applyVec(64'hffffffffffffffff, 7'd0, 1, 15, 5, "R5 R4 wwrap", 0, 0, 1, 64'hfffffffffc01ffff);

    // Wrap edge sweep: end = begin-1 (full) and end = begin (single)
    for (int p = 0; p < 64; p++) begin
      applyVec(64'hdeadbeef12345678, 7'(p), 0, 6'(p), 6'(p - 1), "R4 edge");
      applyVec(64'h0123456789abcdef, 7'(p), 0, 6'(p), 6'(p), "R3 single");
      applyVec(64'hcafef00d87654321, 7'(p), 1, 6'(p), 6'(p - 1), "R2 R5 edge");
    end

    // Pseudo-random run
    lfsr = 64'h9e3779b97f4a7c15;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      applyVec(lfsr, lfsr[13:7], lfsr[20], lfsr[26:21], lfsr[32:27], "R1 R2 R3 R4 rand");
    end

    // R8: inputs change without inValid; outputs must hold
    @(negedge clk);
    inValid = 1'b0; srcValue = 64'h5555aaaa5555aaaa; shiftAmt = 7'd33;
    maskBegin = 6'd3; maskEnd = 6'd9; wordMode = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check64("R8 hold rotated", outRotated, lastExp.rot);
    check64("R8 hold mask", outMask, lastExp.msk);
    check64("R8 hold result", outResult, lastExp.res);
    check64("R8 valid low", {63'd0, outValid}, '0);
    check64("R7 queue drained", 64'(scoreQ.size()), '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule